// File: doc/BRIEF.md
# LCD Column Driver Digital Front-End

This block is the digital part of a six-channel LCD column driver. A start token enters on one of two cascade pins and moves through a sampling shift register, one stage per sampling clock. While the token sits at a stage, that stage's channel takes its 2-bit grey code from a 6-bit bus that carries red, green and blue side by side. The codes build up in a first-rank latch. A rising edge on a separate load clock then copies all of them at once into a second-rank latch, which drives the outputs.

Each output channel gives a 3-bit reference index for the analog section. The top bit picks the positive or the negative reference bank. The polarity pattern alternates from one channel to the next (dot inversion) and a polarity input flips it. The low two bits give the level inside the chosen bank. A direction input swaps the roles of the two cascade pins and reverses the order in which channels are sampled, so that drivers can be chained either way.

Top module: `lcd_col_front`

## Requirements
- R1: An active-high synchronous reset clears the token, both latch ranks and the cascade outputs. After reset every channel's level bits read 0.
- R2: A start pulse on the active cascade input, sampled at clock edge t, places the token at stage 0. Stage s captures its channel's code at edge t+1+s.
- R3: Channel k takes its code from a bus field chosen by k mod 3: channels 0 and 3 read dataIn[1:0] (red), channels 1 and 4 read dataIn[3:2] (green), channels 2 and 5 read dataIn[5:4] (blue).
- R4: The cascade output rises one cycle after edge t+6 and lasts one cycle. It appears on the pin opposite the active input, and the other output stays low.
- R5: With dirRev=0 the active input is cascAIn, stage s drives channel s, and the cascade leaves on cascBOut. With dirRev=1 the active input is cascBIn, stage s drives channel 5-s, and the cascade leaves on cascAOut.
- R6: If loadClk is first seen high at edge e and was low before, the second rank takes the first rank's contents at edge e+2. Between such loads the level bits do not change.
- R7: Output index bits [3k+2] select the bank, with 1 meaning positive. Channel k is positive when k mod 2 equals pol, so adjacent channels always have opposite polarity.
- R8: Index bits [3k+1:3k] equal the channel's second-rank code, and code 0 selects the lowest voltage of either bank.
- R9: A start pulse that arrives during a scan restarts the scan at stage 0. Channels already sampled keep their codes until they are sampled again.
- R10: A load that lands during a scan copies the partly filled first rank as it stands at that edge.
- R11: A pulse on the inactive cascade input starts no scan, samples nothing and produces no cascade output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| dirRev | input | 1 | Shift direction; 1 reverses the order |
| cascAIn | input | 1 | Start input of cascade pin A |
| cascBIn | input | 1 | Start input of cascade pin B |
| cascAOut | output | 1 | Cascade output on pin A (reverse mode) |
| cascBOut | output | 1 | Cascade output on pin B (forward mode) |
| dataIn | input | 6 | Grey codes: red [1:0], green [3:2], blue [5:4] |
| loadClk | input | 1 | Second clock; its rising edge triggers the rank transfer |
| pol | input | 1 | Dot-inversion polarity |
| refIdx | output | 18 | Per-channel {bank, level[1:0]}; channel k at [3k+2:3k] |

## Verification
The bench targets four kinds of fault:
- A sampling order that is off by one edge, or a field chosen by channel number instead of by k mod 3, stores shifted or mixed-up colours.
- In reverse mode, a design that failed to mirror the channels or swap the cascade pins fills the wrong channels or raises the wrong output.
- A restart that arrives mid-scan, and a load that arrives mid-scan, are both driven on purpose. A design that ignored the restart, or that buffered the load until the scan ended, would give outputs that differ from the partial state the bench expects.
- A pulse on the inactive pin, and a polarity flip with no load, check that nothing samples by mistake and that the bank bits follow pol without touching the levels.

// File: rtl/lcd_front_pkg.sv
package lcd_front_pkg;
  localparam int MAX_CH = 16;

  typedef struct packed {
    logic [MAX_CH-1:0] capEn;
    logic              load;
  } ctrlStrobes_t;
endpackage

// File: rtl/lcd_front_ctrl.sv
module lcd_front_ctrl
  import lcd_front_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dirRev,
  input  logic         cascAIn,
  input  logic         cascBIn,
  input  logic         loadClk,
  output ctrlStrobes_t strb,
  output logic         cascAOut,
  output logic         cascBOut
);
  logic [NCH-1:0] token;
  logic           cascReg;
  logic [2:0]     ldSync;
  logic           startHit;

  assign startHit = dirRev ? cascBIn : cascAIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      token   <= '0;
      cascReg <= 1'b0;
      ldSync  <= '0;
    end else begin
      if (startHit) token <= {{(NCH-1){1'b0}}, 1'b1};
      else          token <= token << 1;
      cascReg <= token[NCH-1];
      ldSync  <= {ldSync[1:0], loadClk};
    end
  end

  always_comb begin
    strb = '0;
    strb.load = ldSync[1] & ~ldSync[2];
    for (int k = 0; k < NCH; k++) begin
      strb.capEn[k] = dirRev ? token[NCH-1-k] : token[k];
    end
  end

  assign cascAOut = cascReg & dirRev;
  assign cascBOut = cascReg & ~dirRev;
endmodule

// File: rtl/lcd_front_dpath.sv
module lcd_front_dpath
  import lcd_front_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int CODEW  = 2,
  parameter int NCOLOR = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NCOLOR*CODEW-1:0]    dataIn,
  input  logic                       pol,
  input  ctrlStrobes_t               strb,
  output logic [NCH*(CODEW+1)-1:0]   refIdx
);
  localparam int IDXW = CODEW + 1;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam int FIELD = k % NCOLOR;
    localparam bit ODD   = (k % 2) == 1;
    logic [CODEW-1:0] r1Q;
    logic [CODEW-1:0] r2Q;

    always_ff @(posedge clk) begin
      if (rst)                r1Q <= '0;
      else if (strb.capEn[k]) r1Q <= dataIn[FIELD*CODEW +: CODEW];
    end

    always_ff @(posedge clk) begin
      if (rst)            r2Q <= '0;
      else if (strb.load) r2Q <= r1Q;
    end

    assign refIdx[k*IDXW +: IDXW] = {(pol == ODD), r2Q};
  end
endmodule

// File: rtl/lcd_col_front.sv
module lcd_col_front
  import lcd_front_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int CODEW  = 2,
  parameter int NCOLOR = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     dirRev,
  input  logic                     cascAIn,
  input  logic                     cascBIn,
  output logic                     cascAOut,
  output logic                     cascBOut,
  input  logic [NCOLOR*CODEW-1:0]  dataIn,
  input  logic                     loadClk,
  input  logic                     pol,
  output logic [NCH*(CODEW+1)-1:0] refIdx
);
  ctrlStrobes_t strb;

  lcd_front_ctrl #(.NCH(NCH)) ctrl_i (
    .clk(clk), .rst(rst), .dirRev(dirRev), .cascAIn(cascAIn), .cascBIn(cascBIn),
    .loadClk(loadClk), .strb(strb), .cascAOut(cascAOut), .cascBOut(cascBOut)
  );

  lcd_front_dpath #(.NCH(NCH), .CODEW(CODEW), .NCOLOR(NCOLOR)) dpath_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .pol(pol), .strb(strb), .refIdx(refIdx)
  );
endmodule

// File: rtl/lcd_col_front_chk.sv
module lcd_col_front_chk
  import lcd_front_pkg::*;
#(
  parameter int NCH   = 6,
  parameter int CODEW = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cascAOut,
  input logic                     cascBOut,
  input logic                     pol,
  input logic [NCH*(CODEW+1)-1:0] refIdx,
  input ctrlStrobes_t             strb
);
  localparam int IDXW = CODEW + 1;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!cascAOut && !cascBOut));

  assert_one_stage_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.capEn));

  assert_casc_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(cascAOut && cascBOut));

  assert_casc_src_R4: assert property (@(posedge clk) disable iff (rst)
    (cascAOut || cascBOut) |-> (!$past(rst) && $past(strb.capEn[0] || strb.capEn[NCH-1])));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ($stable(pol) && !$past(rst) && !$past(strb.load)) |-> $stable(refIdx));

  for (genvar k = 0; k < NCH - 1; k++) begin : g_alt
    assert_alt_pol_R7: assert property (@(posedge clk) disable iff (rst)
      refIdx[k*IDXW + CODEW] != refIdx[(k+1)*IDXW + CODEW]);
  end
endmodule

bind lcd_col_front lcd_col_front_chk #(.NCH(NCH), .CODEW(CODEW)) chk_i (
  .clk(clk), .rst(rst), .cascAOut(cascAOut), .cascBOut(cascBOut),
  .pol(pol), .refIdx(refIdx), .strb(strb)
);

// File: tb/lcd_col_front_tb.sv
`timescale 1ns/1ps
module lcd_col_front_tb_top;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dirRev = 1'b0;
  logic        cascAIn = 1'b0;
  logic        cascBIn = 1'b0;
  logic [5:0]  dataIn = '0;
  logic        loadClk = 1'b0;
  logic        pol = 1'b0;
  logic        cascAOut, cascBOut;
  logic [17:0] refIdx;

  int checks = 0;
  int errors = 0;
  int pc = 0;

  // bench model
  int mR1 [NCH];
  int mR2 [NCH];
  int mTok = -1;
  bit mCasc = 0;
  bit l0 = 0, l1 = 0, l2 = 0;

  always #4 clk = ~clk;

  lcd_col_front dut_i (
    .clk(clk), .rst(rst), .dirRev(dirRev), .cascAIn(cascAIn), .cascBIn(cascBIn),
    .cascAOut(cascAOut), .cascBOut(cascBOut), .dataIn(dataIn), .loadClk(loadClk),
    .pol(pol), .refIdx(refIdx)
  );

  function automatic int fieldOf(int ch, logic [5:0] d);
    return int'((d >> (2 * (ch % 3))) & 6'd3);
  endfunction

  function automatic logic [17:0] expRef();
    logic [17:0] v;
    v = '0;
    for (int k = 0; k < NCH; k++) begin
      v[3*k+2]   = ((k % 2) == int'(pol));
      v[3*k +: 2] = 2'(mR2[k]);
    end
    return v;
  endfunction

  task automatic modelEdge();
    bit fire;
    bit st;
    if (rst) begin
      for (int k = 0; k < NCH; k++) begin mR1[k] = 0; mR2[k] = 0; end
      mTok = -1; mCasc = 0; l0 = 0; l1 = 0; l2 = 0;
      return;
    end
    fire = l1 && !l2;
    if (fire) for (int k = 0; k < NCH; k++) mR2[k] = mR1[k];
    if (mTok >= 0) begin
      int ch;
      ch = dirRev ? (NCH - 1 - mTok) : mTok;
      mR1[ch] = fieldOf(ch, dataIn);
    end
    mCasc = (mTok == NCH - 1);
    st = dirRev ? cascBIn : cascAIn;
    if (st) mTok = 0;
    else if (mTok >= 0 && mTok < NCH - 1) mTok = mTok + 1;
    else mTok = -1;
    l2 = l1; l1 = l0; l0 = loadClk;
  endtask

  task automatic step(input string tag);
    logic [17:0] e;
    bit ea, eb;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    e  = expRef();
    ea = mCasc && dirRev;
    eb = mCasc && !dirRev;
    checks++;
    if (refIdx !== e || cascAOut !== ea || cascBOut !== eb) begin
      errors++;
      $display("FAIL %s: refIdx=%h cascA=%b cascB=%b expected refIdx=%h cascA=%b cascB=%b",
               tag, refIdx, cascAOut, cascBOut, e, ea, eb);
    end
  endtask

  task automatic patData();
    dataIn = {2'(pc + 2), 2'(pc + 1), 2'(pc)};
    pc++;
  endtask

  task automatic startPulse(input bit onB, input string tag);
    if (onB) cascBIn = 1'b1; else cascAIn = 1'b1;
    patData();
    step(tag);
    cascAIn = 1'b0; cascBIn = 1'b0;
  endtask

  task automatic doLoad(input string tag);
    loadClk = 1'b1;
    for (int i = 0; i < 4; i++) step(tag);
    loadClk = 1'b0;
    for (int i = 0; i < 2; i++) step(tag);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0042);
    @(negedge clk);
    step("R1"); step("R1");
    rst = 1'b0;
    step("R1");

    // forward scan with the colour test pattern
    startPulse(1'b0, "R2");
    for (int s = 0; s < 8; s++) begin patData(); step("R3 R4"); end
    doLoad("R6 R8");
    pol = 1'b1; step("R7");
    pol = 1'b0; step("R7");

    // reverse direction
    dirRev = 1'b1;
    startPulse(1'b1, "R5");
    for (int s = 0; s < 8; s++) begin dataIn = 6'($urandom); step("R5"); end
    doLoad("R5 R6");

    // inactive pin ignored
    dirRev = 1'b0;
    startPulse(1'b1, "R11");
    for (int s = 0; s < 8; s++) begin dataIn = 6'($urandom); step("R11"); end
    doLoad("R11");

    // restart mid-scan
    startPulse(1'b0, "R9");
    for (int s = 0; s < 3; s++) begin dataIn = 6'($urandom); step("R9"); end
    startPulse(1'b0, "R9");
    for (int s = 0; s < 8; s++) begin dataIn = 6'($urandom); step("R9"); end
    doLoad("R9");

    // load mid-scan
    startPulse(1'b0, "R10");
    dataIn = 6'($urandom); step("R10");
    loadClk = 1'b1;
    for (int s = 0; s < 4; s++) begin dataIn = 6'($urandom); step("R10"); end
    loadClk = 1'b0;
    for (int s = 0; s < 6; s++) begin dataIn = 6'($urandom); step("R10"); end
    doLoad("R10");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      dataIn  = 6'($urandom);
      if (($urandom % 40) == 0) dirRev = ~dirRev;
      if (($urandom % 7) == 0)  pol = ~pol;
      cascAIn = (($urandom % 12) == 0);
      cascBIn = (($urandom % 12) == 0);
      if (($urandom % 5) == 0)  loadClk = ~loadClk;
      step("R2 R6 R7");
    end
    cascAIn = 1'b0; cascBIn = 1'b0;

    rst = 1'b1; step("R1");
    rst = 1'b0; step("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule